// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt events from a bank of peripheral sources and drives a single request line toward a processor core. Each event is captured in a pending register, and a per-source enable mask decides whether a captured event may compete for the core. Among the competing sources, the one with the highest fixed priority wins. Priority follows the source index: a larger index means a higher priority.

Software works the block through four word-wide registers, selected by a two-bit address. An acknowledge is a write of bit 31 to the vector register. On that write the block latches the winning source index as the vector number and clears that source's pending bit. It also marks the source as in service. While a source is in service, no source at its priority or lower may raise a request. A strictly higher source can still interrupt the handler that is running. Once software clears the in-service bit, the lower sources may request again.

Blocked and masked sources keep recording events, so software can service them later. With every source masked, software can poll the pending register instead of taking interrupts.

Top module: `nirq_ctrl`

## Requirements
- R1: After reset, the pending, enable and in-service registers read 0, the request line is low, and the vector register reads 0x0000001F.
- R2: A high level on `src_irq[i]` during a cycle sets pending bit i at that clock edge, whatever the state of enable bit i. The pending register reads at address 0.
- R3: Writing a 1 to bit i of address 0 clears pending bit i, and writing a 0 leaves the bit unchanged. When a source event and a clear hit the same bit in the same cycle, the bit ends up set.
- R4: The enable register, at address 1, is read/write and has one bit per source, where 1 enables the source. A source whose enable bit is 0 never causes a request. With all bits 0, the request line stays low however many bits are pending.
- R5: The request line is a register. One cycle after any cycle in which some source is pending, enabled and above every in-service level, the line is high unless that cycle held an acknowledge. One cycle after a cycle in which no source meets those conditions, the line is low.
- R6: An acknowledge is a write to address 3 with bit 31 set. At the next edge, bits [4:0] of address 3 take the index of the highest-priority eligible source, and that source's pending bit clears. Bit 31 of address 3 reads 1 for exactly the cycle after the acknowledge and 0 otherwise.
- R7: An acknowledge that finds an eligible source sets that source's bit in the in-service register, at address 2.
- R8: While in-service bit k is set, sources with index k or lower raise no request but still set their pending bits. A pending, enabled source with index above every set in-service bit does raise a request.
- R9: Writing a 1 to bit i of address 2 clears in-service bit i, which lets lower sources request again.
- R10: An acknowledge that finds no eligible source sets the vector field to 31 (all ones), changes no in-service bit and clears no pending bit.
- R11: The request line is low in the cycle after an acknowledge. It can be high again at the earliest one cycle after that, if a source is eligible at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Per-source event inputs, sampled every cycle |
| reg_addr | input | 2 | Register select: 0 pending, 1 enable, 2 in-service, 3 vector |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_req | output | 1 | Registered interrupt request to the core |

## Verification
The hardest situation to reach from the ports is a nested acknowledge. It needs a handler already in service, a strictly higher source arriving while lower ones wait blocked, and a request that reasserts exactly one cycle after the acknowledge. The directed sequence builds this step by step: it acknowledges a mid-priority source, injects lower and higher sources, and injects a higher source on the same edge as an acknowledge. The random phase then mixes sparse single-source events with writes of random data to all four registers, including in-service clears. Over a long run this produces many stacked in-service levels, which are checked against a bench model on every cycle.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  typedef enum logic [1:0] {
    SEL_PEND = 2'd0,
    SEL_ENAB = 2'd1,
    SEL_INSV = 2'd2,
    SEL_VECT = 2'd3
  } nirq_sel_e;

  localparam int NIRQ_REG_W = 32;
endpackage

// File: rtl/nirq_state_bank.sv
module nirq_state_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_irq,
  input  logic [NSRC-1:0] pend_clr,
  input  logic            enab_we,
  input  logic [NSRC-1:0] enab_wdata,
  input  logic [NSRC-1:0] insv_clr,
  input  logic [NSRC-1:0] grant_oh,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] enab_q,
  output logic [NSRC-1:0] insv_q
);
  logic [NSRC-1:0] pend_d, enab_d, insv_d;

  // next state: a new event beats any clear of the same bit
  always_comb begin
    pend_d = (pend_q & ~pend_clr & ~grant_oh) | src_irq;
    enab_d = enab_we ? enab_wdata : enab_q;
    insv_d = (insv_q & ~insv_clr) | grant_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      enab_q <= '0;
      insv_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (enab_we) enab_q <= enab_d;
      insv_q <= insv_d;
    end
  end

  // R2 / R3: an event always lands in pending
  a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq != '0) |=> ((pend_q & $past(src_irq)) == $past(src_irq)));

  // R7: a grant marks its source in service
  a_r7_grant_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_oh != '0) |=> ((insv_q & $past(grant_oh)) == $past(grant_oh)));

  // R6: a granted source leaves pending unless it re-fired
  a_r6_grant_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_oh != '0) |=> ((pend_q & $past(grant_oh) & ~$past(src_irq)) == '0));
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter #(
  parameter int NSRC = 32,
  localparam int VW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] enab,
  input  logic [NSRC-1:0] insv,
  output logic            win_valid,
  output logic [VW-1:0]   win_idx
);
  logic            insv_any;
  logic [VW-1:0]   insv_top;
  logic [NSRC-1:0] level_open;
  logic [NSRC-1:0] eligible;

  // highest level currently in service
  always_comb begin
    insv_any = 1'b0;
    insv_top = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (insv[i]) begin
        insv_any = 1'b1;
        insv_top = VW'(i);
      end
    end
  end

  // a source may compete only above every in-service level
  for (genvar g = 0; g < NSRC; g++) begin : g_level
    assign level_open[g] = !insv_any || (int'(insv_top) < g);
  end

  assign eligible = pend & enab & level_open;

  // fixed priority: highest index wins
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible[i]) begin
        win_valid = 1'b1;
        win_idx   = VW'(i);
      end
    end
  end

  // R4: a winner is always pending and enabled
  a_r4_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend[win_idx] && enab[win_idx]));

  // R8: a winner lies strictly above every in-service bit
  a_r8_winner_above_insv: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> ((insv >> win_idx) == '0));
endmodule

// File: rtl/nirq_ack_unit.sv
module nirq_ack_unit #(
  parameter int NSRC = 32,
  localparam int VW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_req,
  input  logic            win_valid,
  input  logic [VW-1:0]   win_idx,
  output logic [NSRC-1:0] grant_oh,
  output logic [VW-1:0]   vec_q,
  output logic            ack_q,
  output logic            irq_q
);
  logic [VW-1:0] vec_d;
  logic          irq_d;

  always_comb begin
    grant_oh = '0;
    if (ack_req && win_valid) grant_oh[win_idx] = 1'b1;
    vec_d = win_valid ? win_idx : '1;
    irq_d = win_valid && !ack_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '1;
      ack_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ack_req) vec_q <= vec_d;
      ack_q <= ack_req;
      irq_q <= irq_d;
    end
  end

  // R11: request drops right after an acknowledge
  a_r11_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !irq_q);

  // R10: acknowledge with nothing eligible yields the idle vector
  a_r10_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !win_valid) |=> (vec_q == '1));

  // R6: acknowledge with a winner yields its index
  a_r6_vector_index: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && win_valid) |=> (vec_q == $past(win_idx)));
endmodule

// File: rtl/nirq_ctrl.sv
module nirq_ctrl
  import nirq_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int VW  = $clog2(NSRC),
  localparam int RW  = NIRQ_REG_W,
  localparam int ACK = RW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_irq,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [RW-1:0]   reg_wdata,
  output logic [RW-1:0]   reg_rdata,
  output logic            irq_req
);
  nirq_sel_e       sel;
  logic [NSRC-1:0] pend_q, enab_q, insv_q;
  logic [NSRC-1:0] pend_clr, insv_clr, grant_oh;
  logic            enab_we, ack_req;
  logic            win_valid;
  logic [VW-1:0]   win_idx, vec_q;
  logic            ack_q;

  // register write decode
  always_comb begin
    sel      = nirq_sel_e'(reg_addr);
    pend_clr = (reg_wr && sel == SEL_PEND) ? reg_wdata[NSRC-1:0] : '0;
    insv_clr = (reg_wr && sel == SEL_INSV) ? reg_wdata[NSRC-1:0] : '0;
    enab_we  = reg_wr && (sel == SEL_ENAB);
    ack_req  = reg_wr && (sel == SEL_VECT) && reg_wdata[ACK];
  end

  nirq_state_bank #(.NSRC(NSRC)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_irq    (src_irq),
    .pend_clr   (pend_clr),
    .enab_we    (enab_we),
    .enab_wdata (reg_wdata[NSRC-1:0]),
    .insv_clr   (insv_clr),
    .grant_oh   (grant_oh),
    .pend_q     (pend_q),
    .enab_q     (enab_q),
    .insv_q     (insv_q)
  );

  nirq_arbiter #(.NSRC(NSRC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_q),
    .enab      (enab_q),
    .insv      (insv_q),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  nirq_ack_unit #(.NSRC(NSRC)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_req   (ack_req),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .grant_oh  (grant_oh),
    .vec_q     (vec_q),
    .ack_q     (ack_q),
    .irq_q     (irq_req)
  );

  // register read mux
  always_comb begin
    unique case (sel)
      SEL_PEND: reg_rdata = RW'(pend_q);
      SEL_ENAB: reg_rdata = RW'(enab_q);
      SEL_INSV: reg_rdata = RW'(insv_q);
      default:  reg_rdata = {ack_q, {(RW-1-VW){1'b0}}, vec_q};
    endcase
  end

  // R4: all sources disabled means no request next cycle
  a_r4_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_q == '0) |=> !irq_req);

  // R5: a raised request always traces back to an eligible source
  a_r5_req_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_valid) |=> !irq_req);

  // R10: idle acknowledge leaves in-service untouched
  a_r10_idle_no_insv: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !win_valid) |=> (insv_q == $past(insv_q)));
endmodule

// File: tb/tb_nirq_ctrl.sv
`timescale 1ns/1ps
module tb_nirq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src_irq;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the architectural state
  logic [31:0] mp, mm, mi;
  logic [4:0]  mv;
  logic        mack, mirq;

  always #4 clk = ~clk;

  nirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // highest pending & enabled source above the top in-service bit
  function automatic logic [5:0] pick(input logic [31:0] p, input logic [31:0] m, input logic [31:0] s);
    int top = -1;
    logic [5:0] r = 6'd0;
    for (int i = 0; i < 32; i++) if (s[i]) top = i;
    for (int i = 0; i < 32; i++)
      if (p[i] && m[i] && i > top) r = {1'b1, 5'(i)};
    return r;
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return mp;
      2'd1: return mm;
      2'd2: return mi;
      default: return {mack, 26'd0, mv};
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R2";
      2'd1: return "R4";
      2'd2: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input logic [31:0] src, input logic wr, input logic [1:0] a, input logic [31:0] d);
    logic [5:0]  vw;
    logic        ack;
    logic [31:0] g;
    @(negedge clk);
    src_irq = src; reg_wr = wr; reg_addr = a; reg_wdata = d;
    #1;
    check(tag_of(a), reg_rdata, model_read(a));
    check("R5", {31'd0, irq_req}, {31'd0, mirq});
    @(posedge clk);
    vw  = pick(mp, mm, mi);
    ack = wr && a == 2'd3 && d[31];
    g   = (ack && vw[5]) ? (32'd1 << vw[4:0]) : 32'd0;
    mp  = (mp & ~((wr && a == 2'd0) ? d : 32'd0) & ~g) | src;
    if (wr && a == 2'd1) mm = d;
    mi  = (mi & ~((wr && a == 2'd2) ? d : 32'd0)) | g;
    if (ack) mv = vw[5] ? vw[4:0] : 5'h1f;
    mack = ack;
    mirq = ack ? 1'b0 : vw[5];
    #1;
    src_irq = '0; reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic idle();
    step(32'd0, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic ack();
    step(32'd0, 1'b1, 2'd3, 32'h8000_0000);
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int seed;
    seed = 17;
    v = $urandom(seed);
    src_irq = '0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    mp = '0; mm = '0; mi = '0; mv = 5'h1f; mack = 1'b0; mirq = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, v); check("R1", v, 32'd0);
    peek(2'd1, v); check("R1", v, 32'd0);
    peek(2'd2, v); check("R1", v, 32'd0);
    peek(2'd3, v); check("R1", v, 32'h0000_001f);
    check("R1", {31'd0, irq_req}, 32'd0);

    // R2: event latched while disabled; R4: no request
    step(32'd1 << 3, 1'b0, 2'd0, 32'd0);
    peek(2'd0, v); check("R2", v, 32'h0000_0008);
    idle();
    check("R4", {31'd0, irq_req}, 32'd0);

    // R3: clear of bit 3 and same-cycle set/clear of bit 5
    step(32'd1 << 5, 1'b1, 2'd0, (32'd1 << 5) | (32'd1 << 3));
    peek(2'd0, v); check("R3", v, 32'h0000_0020);

    // R5: registered request follows enable with one cycle latency
    step(32'd0, 1'b1, 2'd1, 32'hffff_ffff);
    check("R5", {31'd0, irq_req}, 32'd0);
    idle();
    check("R5", {31'd0, irq_req}, 32'd1);

    // R6/R7: acknowledge picks the highest (9)
    step((32'd1 << 9) | (32'd1 << 4), 1'b0, 2'd0, 32'd0);
    ack();
    check("R11", {31'd0, irq_req}, 32'd0);
    peek(2'd3, v); check("R6", v, 32'h8000_0009);
    peek(2'd2, v); check("R7", v, 32'h0000_0200);
    peek(2'd0, v); check("R6", v, 32'h0000_0030);
    idle();
    peek(2'd3, v); check("R6", v, 32'h0000_0009);
    check("R8", {31'd0, irq_req}, 32'd0);

    // R8: lower source blocked but pending, higher source nests
    step(32'd1 << 7, 1'b0, 2'd0, 32'd0);
    idle();
    peek(2'd0, v); check("R8", v, 32'h0000_00b0);
    check("R8", {31'd0, irq_req}, 32'd0);
    step(32'd1 << 20, 1'b0, 2'd0, 32'd0);
    idle();
    check("R8", {31'd0, irq_req}, 32'd1);
    ack();
    peek(2'd3, v); check("R8", v, 32'h8000_0014);
    peek(2'd2, v); check("R8", v, 32'h0010_0200);

    // R9: clearing in-service bits reopens lower levels
    step(32'd0, 1'b1, 2'd2, 32'd1 << 20);
    idle();
    check("R9", {31'd0, irq_req}, 32'd0);
    step(32'd0, 1'b1, 2'd2, 32'd1 << 9);
    idle();
    check("R9", {31'd0, irq_req}, 32'd1);
    ack();
    peek(2'd3, v); check("R9", v, 32'h8000_0007);

    // R11: reassert one cycle after an acknowledge
    step(32'd0, 1'b1, 2'd2, 32'd1 << 7);
    idle();
    step(32'd1 << 25, 1'b1, 2'd3, 32'h8000_0000);
    check("R11", {31'd0, irq_req}, 32'd0);
    peek(2'd3, v); check("R11", v, 32'h8000_0005);
    idle();
    check("R11", {31'd0, irq_req}, 32'd1);
    ack();
    peek(2'd3, v); check("R11", v, 32'h8000_0019);

    // R10: acknowledge with nothing eligible
    step(32'd0, 1'b1, 2'd0, 32'hffff_ffff);
    step(32'd0, 1'b1, 2'd2, 32'hffff_ffff);
    ack();
    peek(2'd3, v); check("R10", v, 32'h8000_001f);
    peek(2'd2, v); check("R10", v, 32'd0);

    // R4: polling with everything disabled
    step(32'd0, 1'b1, 2'd1, 32'd0);
    step(32'h8421_1248, 1'b0, 2'd0, 32'd0);
    idle();
    idle();
    check("R4", {31'd0, irq_req}, 32'd0);
    peek(2'd0, v); check("R4", v, 32'h8421_1248);

    // random phase against the model
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] s, d;
      logic        w;
      logic [1:0]  a;
      s = ($urandom % 3 == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
      w = ($urandom % 10) < 4;
      a = 2'($urandom % 4);
      case (a)
        2'd1:    d = $urandom | $urandom;
        2'd3:    d = {1'($urandom % 2), 31'($urandom)};
        default: d = $urandom & $urandom & $urandom;
      endcase
      step(s, w, a, d);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule